// File: doc/BRIEF.md
# Asynchronous Registered Output Cell

This block models one output cell of a sum-of-products programmable logic array whose flip-flop is clocked from its own product term. The array supplies five terms: the data sum, a private clock term, an asynchronous set term, an asynchronous clear term and a local output-enable term. The block adds a shared active-low enable pin, an active-low load strobe with the value taken from the pin, and a polarity configuration bit. It drives a pad value, a pad enable and a feedback bit back into the array.

The cell runs inside a fast system clock domain. Every term is sampled on the system clock. Edges on the clock term and the load strobe are found by comparing each sample with the one before it. The set and clear terms act on the next system edge and take precedence over everything else. When set and clear are both high, the flip-flop is skipped and the pad follows the data sum combinatorially. The polarity bit conditions the data before it is stored. A fixed inverter then sits between the stored bit and the pad. After power-on the registered pad therefore reads high whatever the polarity setting.

Top module: `ra_macrocell`

## Requirements
- R1: A synchronous reset clears the stored bit to 0. In registered mode the pad value then reads 1 and the feedback reads 0 for either polarity.
- R2: The stored bit is loaded only on a rising edge of the clock term. The edge is seen at the system edge where the term is high and was low one sample before. Holding the term high or dropping it leaves the pad unchanged.
- R3: Set high with clear low makes the pad read 0 from the next system cycle. This overrides a clock-term edge in the same cycle.
- R4: Clear high with set low makes the pad read 1 from the next system cycle. This overrides a clock-term edge in the same cycle.
- R5: While set and clear are both high, the pad follows the data sum in the same cycle: it equals sum when polarity is 1 and NOT sum when polarity is 0. The stored bit keeps its previous value through this bypass.
- R6: After a clock-term edge in registered mode, the pad equals the sampled sum when polarity is 1 and its inverse when polarity is 0.
- R7: The pad enable is 1 exactly when the shared enable pin is 0 and the local enable term is 1.
- R8: A falling edge on the load strobe stores the inverse of the pin-side value, so the pad then shows that value again. A load in the same cycle as a clock-term edge wins over the clock.
- R9: A load yields to set or clear arriving in the same cycle.
- R10: The feedback bit is always the complement of the pad value. That is the stored bit in registered mode and sum XOR polarity in bypass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| sum_pt | input | 1 | Data sum-of-products term |
| clk_pt | input | 1 | Per-cell clock product term |
| set_pt | input | 1 | Asynchronous set product term |
| clr_pt | input | 1 | Asynchronous clear product term |
| oe_pt | input | 1 | Local output-enable product term |
| oe_n_pin | input | 1 | Shared active-low output enable |
| ld_n | input | 1 | Active-low load strobe |
| ld_pin | input | 1 | Pin-side level captured by a load |
| pol_bit | input | 1 | Polarity: 1 active-high, 0 active-low |
| pad_val | output | 1 | Value driven to the pad |
| pad_en | output | 1 | Pad driver enable |
| fb | output | 1 | Feedback into the array |

## Verification
A corrupted stored bit shows on the pad one system cycle after the event that set it, whenever the cell is in registered mode. Bypass hides it, and it reappears on the first cycle after set and clear drop. A missed or spurious edge on the clock term or load strobe shows as a wrong pad level at the next sample. The sweeps cover each polarity and data combination, so a swapped polarity shows in both modes.

// File: rtl/ra_mc_pkg.sv
package ra_mc_pkg;
  typedef enum logic [1:0] {
    CTL_NONE = 2'd0,
    CTL_SET  = 2'd1,
    CTL_CLR  = 2'd2,
    CTL_BYP  = 2'd3
  } cell_ctl_e;

  function automatic cell_ctl_e decode_ctl(input logic set_t, input logic clr_t);
    return cell_ctl_e'({clr_t, set_t});
  endfunction
endpackage

// File: rtl/ra_mc_edge.sv
module ra_mc_edge #(
  parameter bit INIT = 1'b1,
  parameter bit RISE = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic sig,
  output logic hit
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= INIT;
    else     prev_q <= sig;
  end

  generate
    if (RISE) begin : g_rise
      assign hit = sig & ~prev_q;
    end else begin : g_fall
      assign hit = ~sig & prev_q;
    end
  endgenerate
endmodule

// File: rtl/ra_mc_store.sv
module ra_mc_store
  import ra_mc_pkg::*;
#(
  parameter bit RST_VAL = 1'b0
) (
  input  logic      clk,
  input  logic      rst,
  input  cell_ctl_e ctl,
  input  logic      ld_hit,
  input  logic      ld_val,
  input  logic      cap_hit,
  input  logic      cap_val,
  output logic      q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= RST_VAL;
    end else begin
      unique case (ctl)
        CTL_BYP:  q <= q;
        CTL_SET:  q <= 1'b1;
        CTL_CLR:  q <= 1'b0;
        default: begin
          if (ld_hit)       q <= ld_val;
          else if (cap_hit) q <= cap_val;
        end
      endcase
    end
  end
endmodule

// File: rtl/ra_mc_outpath.sv
module ra_mc_outpath
  import ra_mc_pkg::*;
(
  input  logic      q,
  input  logic      d_int,
  input  cell_ctl_e ctl,
  input  logic      oe_n_pin,
  input  logic      oe_pt,
  output logic      pad_val,
  output logic      pad_en,
  output logic      fb
);
  logic core_bit;

  always_comb begin
    core_bit = (ctl == CTL_BYP) ? d_int : q;
    fb       = core_bit;
    pad_val  = ~core_bit;
    pad_en   = ~oe_n_pin & oe_pt;
  end
endmodule

// File: rtl/ra_macrocell.sv
module ra_macrocell
  import ra_mc_pkg::*;
#(
  parameter bit POWERUP_BIT = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic sum_pt,
  input  logic clk_pt,
  input  logic set_pt,
  input  logic clr_pt,
  input  logic oe_pt,
  input  logic oe_n_pin,
  input  logic ld_n,
  input  logic ld_pin,
  input  logic pol_bit,
  output logic pad_val,
  output logic pad_en,
  output logic fb
);
  localparam bit STROBE_IDLE = 1'b1;

  cell_ctl_e ctl;
  logic      d_int;
  logic      cap_hit;
  logic      ld_hit;
  logic      q;

  assign ctl   = decode_ctl(set_pt, clr_pt);
  assign d_int = sum_pt ^ pol_bit;

  ra_mc_edge #(.INIT(STROBE_IDLE), .RISE(1'b1)) u_clk_edge (
    .clk(clk), .rst(rst), .sig(clk_pt), .hit(cap_hit)
  );

  ra_mc_edge #(.INIT(STROBE_IDLE), .RISE(1'b0)) u_ld_edge (
    .clk(clk), .rst(rst), .sig(ld_n), .hit(ld_hit)
  );

  ra_mc_store #(.RST_VAL(POWERUP_BIT)) u_store (
    .clk(clk), .rst(rst), .ctl(ctl),
    .ld_hit(ld_hit), .ld_val(~ld_pin),
    .cap_hit(cap_hit), .cap_val(d_int),
    .q(q)
  );

  ra_mc_outpath u_out (
    .q(q), .d_int(d_int), .ctl(ctl),
    .oe_n_pin(oe_n_pin), .oe_pt(oe_pt),
    .pad_val(pad_val), .pad_en(pad_en), .fb(fb)
  );
endmodule

// File: rtl/ra_macrocell_chk.sv
module ra_macrocell_chk (
  input logic clk,
  input logic rst,
  input logic sum_pt,
  input logic set_pt,
  input logic clr_pt,
  input logic oe_pt,
  input logic oe_n_pin,
  input logic ld_n,
  input logic ld_pin,
  input logic pol_bit,
  input logic pad_val,
  input logic pad_en,
  input logic fb
);
  logic byp;
  assign byp = set_pt & clr_pt;

  AST_RESET_HIGH: assert property (@(posedge clk)
    $past(rst) && !byp |-> pad_val); // R1

  AST_SET_LOW: assert property (@(posedge clk) disable iff (rst)
    set_pt && !clr_pt |=> byp || !pad_val); // R3

  AST_CLR_HIGH: assert property (@(posedge clk) disable iff (rst)
    clr_pt && !set_pt |=> byp || pad_val); // R4

  AST_BYPASS_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    byp |-> pad_val == (pol_bit ? sum_pt : !sum_pt)); // R5

  AST_ENABLE_GATE: assert property (@(posedge clk) disable iff (rst)
    pad_en == (!oe_n_pin && oe_pt)); // R7

  AST_LOAD_PIN: assert property (@(posedge clk) disable iff (rst)
    $fell(ld_n) && !set_pt && !clr_pt |=> byp || pad_val == $past(ld_pin)); // R8

  AST_FB_COMPL: assert property (@(posedge clk) disable iff (rst)
    fb != pad_val); // R10
endmodule

bind ra_macrocell ra_macrocell_chk u_chk (
  .clk(clk), .rst(rst), .sum_pt(sum_pt), .set_pt(set_pt), .clr_pt(clr_pt),
  .oe_pt(oe_pt), .oe_n_pin(oe_n_pin), .ld_n(ld_n), .ld_pin(ld_pin),
  .pol_bit(pol_bit), .pad_val(pad_val), .pad_en(pad_en), .fb(fb)
);

// File: tb/sim_ra_macrocell.sv
`timescale 1ns/1ps
module sim_ra_macrocell;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sum_pt = 0, clk_pt = 0, set_pt = 0, clr_pt = 0, oe_pt = 0;
  logic oe_n_pin = 1, ld_n = 1, ld_pin = 0, pol_bit = 0;
  logic pad_val, pad_en, fb;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ra_macrocell u0 (
    .clk(clk), .rst(rst), .sum_pt(sum_pt), .clk_pt(clk_pt), .set_pt(set_pt),
    .clr_pt(clr_pt), .oe_pt(oe_pt), .oe_n_pin(oe_n_pin), .ld_n(ld_n),
    .ld_pin(ld_pin), .pol_bit(pol_bit), .pad_val(pad_val), .pad_en(pad_en), .fb(fb)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic clock_in(input logic s);
    sum_pt = s; clk_pt = 1; tick();
    clk_pt = 0; tick();
  endtask

  task automatic preload(input logic v);
    ld_pin = v; ld_n = 0; tick();
    ld_n = 1; tick();
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk); tick(); tick();
    rst = 0; tick();
    // R1: power-on state for both polarities
    for (int p = 0; p < 2; p++) begin
      pol_bit = p[0]; tick();
      chk("R1 pad after reset", pad_val, 1'b1);
      chk("R10 fb after reset", fb, 1'b0);
    end

    // R2 / R6: registered capture for each polarity and data value
    for (int p = 0; p < 2; p++) begin
      for (int s = 0; s < 2; s++) begin
        logic e;
        pol_bit = p[0];
        e = p[0] ? s[0] : ~s[0];
        sum_pt = s[0]; clk_pt = 1; tick();
        chk("R6 capture", pad_val, e);
        chk("R10 fb registered", fb, ~e);
        sum_pt = ~s[0]; tick();
        chk("R2 level high no load", pad_val, e);
        clk_pt = 0; tick();
        chk("R2 falling no load", pad_val, e);
      end
    end

    // R3: set overrides a clock edge that would give 1
    pol_bit = 1; clock_in(0);
    sum_pt = 1; clk_pt = 1; set_pt = 1; tick();
    chk("R3 set beats clock", pad_val, 1'b0);
    set_pt = 0; clk_pt = 0; tick();
    chk("R3 set holds", pad_val, 1'b0);
    // R4: clear overrides a clock edge that would give 0
    sum_pt = 0; clk_pt = 1; clr_pt = 1; tick();
    chk("R4 clear beats clock", pad_val, 1'b1);
    clr_pt = 0; clk_pt = 0; tick();
    chk("R4 clear holds", pad_val, 1'b1);

    // R5: bypass follows sum in the same cycle, register kept
    for (int r = 0; r < 2; r++) begin
      pol_bit = 1; clock_in(r[0]);
      for (int p = 0; p < 2; p++) begin
        for (int s = 0; s < 2; s++) begin
          pol_bit = p[0]; sum_pt = s[0]; set_pt = 1; clr_pt = 1; clk_pt = 1;
          #1;
          chk("R5 bypass value", pad_val, p[0] ? s[0] : ~s[0]);
          chk("R10 fb bypass", fb, s[0] ^ p[0]);
          tick();
          clk_pt = 0;
        end
      end
      set_pt = 0; clr_pt = 0; #1;
      chk("R5 register kept", pad_val, r[0]);
      tick();
    end

    // R7: enable gating, all four combinations
    for (int k = 0; k < 4; k++) begin
      oe_n_pin = k[1]; oe_pt = k[0]; #1;
      chk("R7 pad enable", pad_en, ~k[1] & k[0]);
      tick();
    end

    // R8: load restores the pin level for each polarity
    for (int p = 0; p < 2; p++) begin
      for (int v = 0; v < 2; v++) begin
        pol_bit = p[0]; preload(v[0]);
        chk("R8 load level", pad_val, v[0]);
      end
    end
    // R8: load beats a simultaneous clock edge
    pol_bit = 1; sum_pt = 0; ld_pin = 1; ld_n = 0; clk_pt = 1; tick();
    chk("R8 load beats clock", pad_val, 1'b1);
    ld_n = 1; clk_pt = 0; tick();

    // R9: load yields to clear and to set
    preload(1);
    ld_pin = 0; ld_n = 0; clr_pt = 1; tick();
    chk("R9 clear beats load", pad_val, 1'b1);
    ld_n = 1; clr_pt = 0; tick();
    ld_pin = 1; ld_n = 0; set_pt = 1; tick();
    chk("R9 set beats load", pad_val, 1'b0);
    ld_n = 1; set_pt = 0; tick();

    // R1: reset in mid-run returns the pad high
    rst = 1; tick(); rst = 0;
    chk("R1 pad after rerun reset", pad_val, 1'b1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule